// File: doc/BRIEF.md
# Two-Word Instruction Fetch Sequencer

This block is the program-counter and fetch stage of a small 8-bit controller core. It holds a byte-addressed program counter, presents one even word address per cycle to a synchronous program memory, and turns the returned 16-bit words into instruction records for the decode stage. A record gives the instruction word, the address it came from, a flag for two-word instructions with both operand fields combined, and a flag saying the record must execute as a no-operation.

Four instruction forms take two words: absolute jump, call, a memory-to-memory move and a pointer load. Their trailing word always starts with the nibble 1111 and carries a 12-bit literal. The sequencer holds the leading word for one cycle and emits one combined record once the trailing word arrives. A trailing word that shows up without its leading word, for instance because the core skipped the leading word, is reported as a no-operation. Its literal takes no effect.

The execute stage steers the sequencer through two inputs. `skip` turns the next word into a no-operation. `branchEn` with a signed word offset moves the PC relative to the current record. Absolute jumps and calls are taken inside the block. Every redirect discards the word already in flight, so exactly one cycle without a record follows.

Top module: `instr_fetch_seq`

## Requirements
- R1: During reset and in the first cycle after it, `memAddr` equals the reset address (0 by default) and `instValid` is low.
- R2: With no redirect, `memAddr` advances by 2 every cycle. The record for a word appears in the cycle after its address was presented, and `instPc` is always even.
- R3: `memRdata[7:0]` is the byte at the even address and `memRdata[15:8]` the byte at the following odd address. `instWord` reports the word unchanged.
- R4: A leading word (bits 15:12 = 1100, bits 15:8 = 0xEF, bits 15:9 = 1110110, or bits 15:6 = 1110111000) yields no record in its own cycle. In the next cycle one record appears with `instPair` high, `instWord` and `instPc` of the leading word, and `instOperand` = {trailing word[11:0], leading word[11:0]}.
- R5: Any other word whose bits 15:12 are not 1111 yields a record with `instPair` and `instNop` low and `instOperand` = {12'h000, word[11:0]}.
- R6: A word with bits 15:12 = 1111 that does not directly follow a held leading word yields a record with `instNop` high and `instOperand` zero, and it causes no redirect.
- R7: A completed pair whose leading word has bits 15:8 = 0xEF or bits 15:9 = 1110110 redirects to byte address {trailing[11:0], leading[7:0], 0}. The next cycle presents that address with `instValid` low, and the cycle after gives the record from the target.
- R8: `branchEn` high together with `instValid` redirects to (address of the record's last word + 2 + 2 × sign-extended `branchOff`), wrapping in 21 bits. The timing and the one-cycle bubble match R7.
- R9: `skip` high together with a record marks the next word as a no-operation. If that word leads a two-word instruction, both of its words become no-operation records and no jump is taken.
- R10: A redirect in the same cycle as `skip` cancels the skip. The first record at the target has `instNop` low.
- R11: When a jump or call record and `branchEn` coincide, the absolute target wins.
- R12: Move and pointer-load pairs never redirect. Fetching continues sequentially after them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| memAddr | output | AW (21) | Byte address presented to program memory |
| memRdata | input | 16 | Word read from the address of the previous cycle |
| skip | input | 1 | Turn the next word into a no-operation |
| branchEn | input | 1 | Take a relative branch from the current record |
| branchOff | input | OW (11) | Signed branch offset in words |
| instValid | output | 1 | A record is present this cycle |
| instWord | output | 16 | Instruction word (leading word for pairs) |
| instPc | output | AW (21) | Byte address of the record's first word |
| instPair | output | 1 | Record is a two-word instruction |
| instNop | output | 1 | Record must execute as a no-operation |
| instOperand | output | 24 | Pair: {trailing[11:0], leading[11:0]}; single: {0, word[11:0]}; zero for no-operation |

## Verification
Two functions can fall in one cycle. The first is a skip request together with a redirect: a relative branch, or the completion of a jump pair. The second is a relative branch together with a jump completion. The bench raises `skip` on the same record that carries `branchEn`, and separately on the record of a completed jump. It judges the result by the address presented in the next cycle, the bubble, and whether the first record at the target is clean. It raises `branchEn` on a jump record and expects the absolute target. Sweeps over every branch offset, many jump targets and every trailing-word literal supply the expected addresses arithmetically.

// File: rtl/ifs_pkg.sv
package ifs_pkg;

  // Strobes handed from the control to the datapath each cycle
  typedef struct packed {
    logic emit;      // a record is presented this cycle
    logic pair;      // the record combines a held leading word with this word
    logic nop;       // the record must execute as a no-operation
    logic load;      // hold the current word as a leading word
    logic redirect;  // load the PC with a new target at the next edge
    logic selJump;   // target is the absolute jump target, else the branch target
  } ifsStrobes_t;

  // What the control decided to do with the word in the data stage
  typedef enum logic [2:0] {
    K_IDLE,
    K_PAIR,
    K_SKIPPED,
    K_HEAD,
    K_ORPHAN,
    K_SINGLE
  } wordKind_t;

  localparam logic [3:0] TAIL_NIB = 4'hF;

  // h carries instruction bits 15:6
  function automatic logic jumpHead(input logic [9:0] h);
    return (h[9:2] == 8'hEF) || (h[9:3] == 7'b1110110);
  endfunction

  function automatic logic pairHead(input logic [9:0] h);
    return jumpHead(h) || (h[9:6] == 4'hC) || (h == 10'b1110111000);
  endfunction

endpackage

// File: rtl/ifs_ctrl.sv
module ifs_ctrl
  import ifs_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [9:0]  headBits,
  input  logic        skip,
  input  logic        branchEn,
  output ifsStrobes_t st
);

  logic      dataValid;
  logic      holdFirst;
  logic      heldJump;
  logic      skipPending;
  logic      isHead;
  logic      isJumpHead;
  logic      isTail;
  wordKind_t kind;

  always_comb begin
    isHead     = pairHead(headBits);
    isJumpHead = jumpHead(headBits);
    isTail     = (headBits[9:6] == TAIL_NIB);
  end

  // Classify the word in the data stage; a held leading word takes priority,
  // then a pending skip, then the word's own encoding.
  always_comb begin
    if (!dataValid)        kind = K_IDLE;
    else if (holdFirst)    kind = K_PAIR;
    else if (skipPending)  kind = K_SKIPPED;
    else if (isHead)       kind = K_HEAD;
    else if (isTail)       kind = K_ORPHAN;
    else                   kind = K_SINGLE;
  end

  always_comb begin
    st = '0;
    unique case (kind)
      K_IDLE:    ;
      K_PAIR:    begin st.emit = 1'b1; st.pair = 1'b1; st.selJump = heldJump; end
      K_SKIPPED: begin st.emit = 1'b1; st.nop = 1'b1; end
      K_HEAD:    st.load = 1'b1;
      K_ORPHAN:  begin st.emit = 1'b1; st.nop = 1'b1; end
      K_SINGLE:  st.emit = 1'b1;
      default:   ;
    endcase
    // a completed jump pair beats a relative branch request
    st.redirect = st.selJump | (st.emit & branchEn);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataValid   <= 1'b0;
      holdFirst   <= 1'b0;
      heldJump    <= 1'b0;
      skipPending <= 1'b0;
    end else begin
      // the word arriving after a redirect was fetched from the old path
      dataValid <= !st.redirect;
      holdFirst <= st.load | (holdFirst & !dataValid);
      if (st.load) heldJump <= isJumpHead;
      if (st.redirect)                    skipPending <= 1'b0;
      else if (st.emit && skip)           skipPending <= 1'b1;
      else if (dataValid && !holdFirst)   skipPending <= 1'b0;
    end
  end

endmodule

// File: rtl/ifs_dpath.sv
module ifs_dpath
  import ifs_pkg::*;
#(
  parameter int          AW       = 21,
  parameter int          OW       = 11,
  parameter logic [AW-1:0] RESET_PC = '0
) (
  input  logic          clk,
  input  logic          rstN,
  input  ifsStrobes_t   st,
  input  logic [15:0]   memRdata,
  input  logic [OW-1:0] branchOff,
  output logic [AW-1:0] memAddr,
  output logic          instValid,
  output logic [15:0]   instWord,
  output logic [AW-1:0] instPc,
  output logic          instPair,
  output logic          instNop,
  output logic [23:0]   instOperand
);

  localparam logic [AW-1:0] STEP   = AW'(2);
  localparam int            EXT_W  = AW - OW - 1;

  logic [AW-1:0] pc;
  logic [AW-1:0] dataAddr;
  logic [15:0]   firstWord;
  logic [AW-1:0] firstAddr;
  logic [AW-1:0] jumpTarget;
  logic [AW-1:0] branchTarget;
  logic [AW-1:0] branchDelta;
  logic [AW-1:0] nextPc;

  // word offset doubled into a byte offset, sign-extended to the PC width
  assign branchDelta  = {{EXT_W{branchOff[OW-1]}}, branchOff, 1'b0};
  assign branchTarget = dataAddr + STEP + branchDelta;
  assign jumpTarget   = AW'({memRdata[11:0], firstWord[7:0], 1'b0});
  assign nextPc       = st.redirect ? (st.selJump ? jumpTarget : branchTarget)
                                    : pc + STEP;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc        <= RESET_PC;
      dataAddr  <= RESET_PC;
      firstWord <= '0;
      firstAddr <= RESET_PC;
    end else begin
      pc       <= nextPc;
      dataAddr <= pc;
      if (st.load) begin
        firstWord <= memRdata;
        firstAddr <= dataAddr;
      end
    end
  end

  always_comb begin
    memAddr   = pc;
    instValid = st.emit;
    instPair  = st.pair;
    instNop   = st.nop;
    instWord  = st.pair ? firstWord : memRdata;
    instPc    = st.pair ? firstAddr : dataAddr;
    if (st.pair)      instOperand = {memRdata[11:0], firstWord[11:0]};
    else if (st.nop)  instOperand = '0;
    else              instOperand = {12'h000, memRdata[11:0]};
  end

endmodule

// File: rtl/instr_fetch_seq.sv
module instr_fetch_seq
  import ifs_pkg::*;
#(
  parameter int            AW       = 21,
  parameter int            OW       = 11,
  parameter logic [AW-1:0] RESET_PC = '0
) (
  input  logic          clk,
  input  logic          rstN,
  output logic [AW-1:0] memAddr,
  input  logic [15:0]   memRdata,
  input  logic          skip,
  input  logic          branchEn,
  input  logic [OW-1:0] branchOff,
  output logic          instValid,
  output logic [15:0]   instWord,
  output logic [AW-1:0] instPc,
  output logic          instPair,
  output logic          instNop,
  output logic [23:0]   instOperand
);

  ifsStrobes_t st;

  ifs_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .headBits (memRdata[15:6]),
    .skip     (skip),
    .branchEn (branchEn),
    .st       (st)
  );

  ifs_dpath #(.AW(AW), .OW(OW), .RESET_PC(RESET_PC)) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .st          (st),
    .memRdata    (memRdata),
    .branchOff   (branchOff),
    .memAddr     (memAddr),
    .instValid   (instValid),
    .instWord    (instWord),
    .instPc      (instPc),
    .instPair    (instPair),
    .instNop     (instNop),
    .instOperand (instOperand)
  );

endmodule

// File: rtl/ifs_chk.sv
module ifs_chk #(
  parameter int AW = 21,
  parameter int OW = 11
) (
  input logic          clk,
  input logic          rstN,
  input logic [AW-1:0] memAddr,
  input logic          skip,
  input logic          branchEn,
  input logic [OW-1:0] branchOff,
  input logic          instValid,
  input logic [15:0]   instWord,
  input logic [AW-1:0] instPc,
  input logic          instPair,
  input logic          instNop,
  input logic [23:0]   instOperand
);

  logic          jumpRec;
  logic [AW-1:0] lastAddr;
  logic [AW-1:0] brTgt;
  logic [AW-1:0] jmpTgt;

  always_comb begin
    jumpRec  = instValid && instPair &&
               ((instWord[15:8] == 8'hEF) || (instWord[15:9] == 7'b1110110));
    lastAddr = instPc + (instPair ? AW'(2) : AW'(0));
    brTgt    = lastAddr + AW'(2) + {{(AW-OW-1){branchOff[OW-1]}}, branchOff, 1'b0};
    jmpTgt   = AW'({instOperand[23:12], instWord[7:0], 1'b0});
  end

  // R2
  seq_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(instValid && (branchEn || jumpRec)) |=> memAddr == $past(memAddr) + AW'(2));

  // R2
  even_pc_chk: assert property (@(posedge clk) disable iff (!rstN)
    instValid |-> (instPc[0] == 1'b0 && memAddr[0] == 1'b0));

  // R6
  orphan_nop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && !instPair && instWord[15:12] == 4'hF) |-> instNop);

  // R6
  nop_operand_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && instNop) |-> (instOperand == 24'h0 && !instPair));

  // R7
  jump_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    jumpRec |=> memAddr == $past(jmpTgt));

  // R8
  branch_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && branchEn && !jumpRec) |=> memAddr == $past(brTgt));

  // R8
  redirect_bubble_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && (branchEn || jumpRec)) |=> !instValid);

  // R9
  skip_nop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && skip && !branchEn && !jumpRec) |=> (instValid && instNop));

endmodule

bind instr_fetch_seq ifs_chk #(.AW(AW), .OW(OW)) u_ifsChk (
  .clk         (clk),
  .rstN        (rstN),
  .memAddr     (memAddr),
  .skip        (skip),
  .branchEn    (branchEn),
  .branchOff   (branchOff),
  .instValid   (instValid),
  .instWord    (instWord),
  .instPc      (instPc),
  .instPair    (instPair),
  .instNop     (instNop),
  .instOperand (instOperand)
);

// File: tb/instr_fetch_seq_bench.sv
`timescale 1ns/1ps
module instr_fetch_seq_bench;

  localparam int AW = 21;
  localparam int OW = 11;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] memAddr;
  logic [15:0]   memRdata = '0;
  logic          skip = 1'b0;
  logic          branchEn = 1'b0;
  logic [OW-1:0] branchOff = '0;
  logic          instValid;
  logic [15:0]   instWord;
  logic [AW-1:0] instPc;
  logic          instPair;
  logic          instNop;
  logic [23:0]   instOperand;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  instr_fetch_seq u_instr_fetch_seq (
    .clk(clk), .rstN(rstN), .memAddr(memAddr), .memRdata(memRdata),
    .skip(skip), .branchEn(branchEn), .branchOff(branchOff),
    .instValid(instValid), .instWord(instWord), .instPc(instPc),
    .instPair(instPair), .instNop(instNop), .instOperand(instOperand)
  );

  always #4 clk = ~clk;

  // program memory model: bytes, low byte at the even address
  logic [7:0] memB [0:511];
  logic       sweepMode = 1'b0;

  always @(posedge clk) begin
    if (sweepMode) memRdata <= {4'hF, memAddr[12:1]};
    else memRdata <= {memB[{memAddr[8:1], 1'b1}], memB[{memAddr[8:1], 1'b0}]};
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // policy for the execute-side controls
  logic          polSkipEn = 1'b0;
  logic [AW-1:0] polSkipPc = '0;
  logic          polBrEn = 1'b0;
  logic [AW-1:0] polBrPc = '0;
  logic [OW-1:0] polBrOff = '0;

  logic          cvld  [0:15];
  logic [AW-1:0] cpc   [0:15];
  logic [15:0]   cword [0:15];
  logic          cnop  [0:15];
  logic          cpair [0:15];
  logic [23:0]   cop   [0:15];
  logic [AW-1:0] cmem  [0:15];

  task automatic chkEq(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clearMem();
    for (int i = 0; i < 512; i++) memB[i] = 8'h00;
  endtask

  task automatic putWord(input int addr, input logic [15:0] w);
    memB[addr & 32'h1FE]         = w[7:0];
    memB[(addr & 32'h1FE) | 1]   = w[15:8];
  endtask

  task automatic doReset();
    rstN = 1'b0; skip = 1'b0; branchEn = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic noPolicy();
    polSkipEn = 1'b0; polBrEn = 1'b0;
  endtask

  task automatic capture(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      skip      = polSkipEn && instValid && (instPc == polSkipPc);
      branchEn  = polBrEn && instValid && (instPc == polBrPc);
      branchOff = polBrOff;
      cvld[i] = instValid; cpc[i] = instPc; cword[i] = instWord;
      cnop[i] = instNop; cpair[i] = instPair; cop[i] = instOperand; cmem[i] = memAddr;
    end
    @(negedge clk);
    skip = 1'b0; branchEn = 1'b0;
  endtask

  task automatic progJump();
    clearMem();
    putWord(0, 16'h0A00);
    putWord(2, 16'hEF80);   // jump, low 8 bits of word address 0x080
    putWord(4, 16'hF000);   // trailing word, high bits 0
    putWord(6, 16'h0B00);
    putWord(12, 16'h0C0C);
    putWord(16'h100, 16'h0101);
  endtask

  initial begin
    // ---- scenario A: reset, sequential fetch, byte order, pairs, orphan
    clearMem();
    memB[0] = 8'h34; memB[1] = 8'h12;   // word 0x1234
    putWord(2, 16'h0E55);
    putWord(4, 16'hF456);
    putWord(6, 16'hC123);
    putWord(8, 16'hF456);
    putWord(10, 16'h2400);
    noPolicy();
    doReset();
    chkEq("R1 reset address", memAddr, 0);
    chkEq("R1 no record after reset", instValid, 0);
    capture(6);
    for (int c = 0; c < 6; c++) chkEq("R2 sequential address", cmem[c], 2 * c + 2);
    chkEq("R3 byte order", cword[0], 16'h1234);
    chkEq("R2 first record address", cpc[0], 0);
    chkEq("R5 single operand", cop[0], 24'h000234);
    chkEq("R5 single flags", {cvld[1], cnop[1], cpair[1]}, 3'b100);
    chkEq("R5 single pc", cpc[1], 2);
    chkEq("R6 orphan flags", {cvld[2], cnop[2], cpair[2]}, 3'b110);
    chkEq("R6 orphan operand", cop[2], 0);
    chkEq("R4 head cycle has no record", cvld[3], 0);
    chkEq("R4 pair flags", {cvld[4], cnop[4], cpair[4]}, 3'b101);
    chkEq("R4 pair word", cword[4], 16'hC123);
    chkEq("R4 pair pc", cpc[4], 6);
    chkEq("R12 move operand", cop[4], 24'h456123);
    chkEq("R12 move no redirect pc", cpc[5], 10);
    chkEq("R5 after pair operand", cop[5], 24'h000400);

    // ---- scenario D: skip over a jump pair
    progJump();
    polSkipEn = 1'b1; polSkipPc = 0; polBrEn = 1'b0;
    doReset();
    capture(5);
    chkEq("R9 skipped head is nop", {cvld[1], cnop[1], cpair[1]}, 3'b110);
    chkEq("R9 skipped head word", cword[1], 16'hEF80);
    chkEq("R9 tail after skip is nop", {cvld[2], cnop[2], cpc[2]}, {2'b11, 21'd4});
    chkEq("R9 no jump taken", cmem[3], 8);
    chkEq("R9 continues", {cvld[3], cnop[3], cpc[3]}, {2'b10, 21'd6});

    // ---- scenario D2: same program, jump taken
    noPolicy();
    doReset();
    capture(5);
    chkEq("R7 jump record", {cvld[2], cpair[2], cnop[2]}, 3'b110);
    chkEq("R7 jump operand", cop[2], 24'h000F80);
    chkEq("R7 target address", cmem[3], 21'h100);
    chkEq("R7 bubble", cvld[3], 0);
    chkEq("R7 target record", {cvld[4], cnop[4], cpc[4]}, {2'b10, 21'h100});
    chkEq("R7 target word", cword[4], 16'h0101);

    // ---- scenario E1: skip and branch in the same cycle
    polSkipEn = 1'b1; polSkipPc = 0;
    polBrEn = 1'b1; polBrPc = 0; polBrOff = 11'd5;
    doReset();
    capture(3);
    chkEq("R8 branch target", cmem[1], 12);
    chkEq("R8 bubble", cvld[1], 0);
    chkEq("R10 branch cancels skip", {cvld[2], cnop[2], cpc[2]}, {2'b10, 21'd12});

    // ---- scenario E2: skip on a jump record
    noPolicy();
    polSkipEn = 1'b1; polSkipPc = 2;
    doReset();
    capture(5);
    chkEq("R10 jump target with skip", cmem[3], 21'h100);
    chkEq("R10 jump cancels skip", {cvld[4], cnop[4], cpc[4]}, {2'b10, 21'h100});

    // ---- scenario F: branch on a jump record
    noPolicy();
    polBrEn = 1'b1; polBrPc = 2; polBrOff = 11'd3;
    doReset();
    capture(5);
    chkEq("R11 jump beats branch", cmem[3], 21'h100);

    // ---- scenario G: pointer-load pair
    clearMem();
    putWord(0, 16'hEE12);
    putWord(2, 16'hF034);
    putWord(4, 16'h0404);
    noPolicy();
    doReset();
    capture(3);
    chkEq("R4 pointer head no record", cvld[0], 0);
    chkEq("R12 pointer pair", {cvld[1], cpair[1], cnop[1], cpc[1]}, {3'b110, 21'd0});
    chkEq("R12 pointer operand", cop[1], 24'h034E12);
    chkEq("R12 pointer no redirect", cmem[2], 6);
    chkEq("R12 pointer next record", cpc[2], 4);

    // ---- sweep: jump and call targets
    clearMem();
    noPolicy();
    for (int i = 0; i < 64; i++) begin
      logic [19:0] k;
      logic [7:0]  hi;
      logic [AW-1:0] tgt;
      k  = 20'((i * 32'h2D2F3 + 7) & 32'hFFFFF) | 20'h4;
      hi = (i % 3 == 0) ? 8'hEF : ((i % 3 == 1) ? 8'hEC : 8'hED);
      tgt = {k, 1'b0};
      putWord(0, {hi, k[7:0]});
      putWord(2, {4'hF, k[19:8]});
      doReset();
      capture(4);
      chkEq("R7 sweep pair operand", cop[1], {k[19:8], hi[3:0], k[7:0]});
      chkEq("R7 sweep target address", cmem[2], tgt);
      chkEq("R7 sweep bubble", cvld[2], 0);
      chkEq("R7 sweep target record", {cvld[3], cpc[3]}, {1'b1, tgt});
    end

    // ---- sweep: every branch offset, including wrap below zero
    clearMem();
    putWord(0, 16'h1111);
    noPolicy();
    polBrEn = 1'b1; polBrPc = 0;
    for (int off = -(1 << (OW - 1)); off < (1 << (OW - 1)); off++) begin
      logic [AW-1:0] tgt;
      tgt = AW'(2 + 2 * off);
      polBrOff = OW'(off);
      doReset();
      capture(3);
      chkEq("R8 sweep target", cmem[1], tgt);
      chkEq("R8 sweep bubble", cvld[1], 0);
      chkEq("R8 sweep landing", {cvld[2], cpc[2]}, {1'b1, tgt});
    end

    // ---- sweep: every trailing literal seen on its own
    noPolicy();
    sweepMode = 1'b1;
    doReset();
    for (int c = 0; c < 4096; c++) begin
      @(negedge clk);
      chkEq("R6 sweep flags", {instValid, instNop, instPair, instPc}, {3'b110, AW'(2 * c)});
      chkEq("R6 sweep word and operand", {instWord, instOperand}, {4'hF, 12'(c), 24'h0});
    end
    sweepMode = 1'b0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule